// File: doc/BRIEF.md
# Isochronous Endpoint Ping-Pong Buffer Manager

This block controls one isochronous endpoint of a full-speed USB device, whether the endpoint sends (IN) or receives (OUT). Isochronous traffic is never retried and has no handshake phase. The endpoint's data-toggle bit therefore carries no sequencing meaning here. It is reused only to choose which of the two packet memory areas the peripheral fills or drains in the current frame. The other area belongs to the application. The toggle flips after each successful transaction, so the application always holds one complete buffer.

Software programs a small configuration word through a write port: a two-bit endpoint type, a two-bit status and the direction. The protocol engine reports start-of-frame, received tokens with their direction, and whether each transaction ended well or badly. The block returns several outputs:
- a one-cycle respond pulse when it accepts a token;
- the buffer indices for the peripheral side and the application side;
- the data PID select;
- a handshake-enable flag;
- a flag for a status value that is illegal in isochronous mode.

Top module: `iso_ep_buf_mgr`

## Requirements
- R1: The endpoint is in isochronous mode exactly when the stored type field equals 2'b10. In that mode `hsEnable` is 0. With any other type it is 1.
- R2: In isochronous mode `pidData1` is 0, which means DATA0 for every packet. With any other type it follows `hwBufSel`.
- R3: `illegalCfg` is 1 exactly when the endpoint is in isochronous mode and the stored status is 2'b01 or 2'b10. Status 2'b00 means disabled and 2'b11 means valid.
- R4: `hwBufSel` equals the receive toggle when the stored direction is 0 (OUT) and the transmit toggle when it is 1 (IN). `appBufSel` is always the inverse of `hwBufSel`.
- R5: A token is accepted when all of the following hold, and `respond` is then high for exactly the next cycle:
  - the endpoint is isochronous with status 2'b11;
  - the token direction (`tokenIsIn`, 1 for IN) matches the stored direction;
  - no transaction is open;
  - the frame has not yet used its slot.
- R6: `xferOk` during an open transaction, with the endpoint still isochronous and valid, flips the toggle of the stored direction at the next edge and closes the transaction.
- R7: `xferFail` during an open transaction closes it without flipping any toggle. The transaction is not retried: no further token is accepted in that frame.
- R8: With status 2'b00 tokens are ignored (no `respond`) and neither toggle ever changes.
- R9: At most one token is accepted per frame. `sofPulse` frees the slot. A token that arrives in the same cycle as `sofPulse` counts for the new frame.
- R10: After reset the type is 2'b00, the status is 2'b00, the direction is 0, both toggles are 0, no transaction is open, and `respond` is 0.
- R11: A configuration write takes effect at the next edge. A token, success or failure in the same cycle is judged against the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgTypeIn | input | 2 | Endpoint type to store (2'b10 = isochronous) |
| cfgStatIn | input | 2 | Endpoint status to store (00 disabled, 11 valid) |
| cfgDirIn | input | 1 | Direction to store (0 OUT, 1 IN) |
| sofPulse | input | 1 | Start-of-frame strobe |
| tokenValid | input | 1 | Token received for this endpoint |
| tokenIsIn | input | 1 | Token direction (1 IN, 0 OUT) |
| xferOk | input | 1 | Open transaction completed successfully |
| xferFail | input | 1 | Open transaction failed (for example a CRC error) |
| respond | output | 1 | One-cycle pulse: token accepted |
| hwBufSel | output | 1 | Memory area used by the peripheral |
| appBufSel | output | 1 | Memory area holding the complete buffer for software |
| pidData1 | output | 1 | Data PID select (0 = DATA0) |
| hsEnable | output | 1 | Handshake phase enabled |
| illegalCfg | output | 1 | Status value not allowed for isochronous traffic |

## Verification
The assertions check four rules on every cycle:
- isochronous mode never enables a handshake or DATA1;
- a disabled endpoint never moves its toggles;
- every swap strobe flips exactly one toggle;
- a failure never swaps.

The bench's scenarios are needed for the rules that span several cycles and depend on ordering: one slot per frame, including a token that coincides with start-of-frame, the no-retry rule after a failure, and configuration writes that meet a token in the same cycle. Only those scenarios show that a swap reaches the toggle of the correct direction and that the application index tracks it.

// File: rtl/iso_ep_pkg.sv
package iso_ep_pkg;
  localparam int TYPE_W = 2;
  localparam int STAT_W = 2;
  localparam logic [TYPE_W-1:0] EP_TYPE_ISO = 2'b10;
  localparam logic [STAT_W-1:0] STAT_OFF    = 2'b00;
  localparam logic [STAT_W-1:0] STAT_LIVE   = 2'b11;

  typedef struct packed {
    logic accept;  // token taken this cycle
    logic swap;    // successful transaction: flip direction toggle
    logic close;   // transaction ends (ok or fail)
  } isoStrobes_t;
endpackage

// File: rtl/iso_ep_ctrl.sv
module iso_ep_ctrl
  import iso_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [TYPE_W-1:0] cfgTypeIn,
  input  logic [STAT_W-1:0] cfgStatIn,
  input  logic              cfgDirIn,
  input  logic              sofPulse,
  input  logic              tokenValid,
  input  logic              tokenIsIn,
  input  logic              xferOk,
  input  logic              xferFail,
  output logic [TYPE_W-1:0] epType,
  output logic [STAT_W-1:0] epStat,
  output logic              epDir,
  output isoStrobes_t       strb,
  output logic              respond
);
  logic inFlight;
  logic frameUsed;
  logic isoLive;
  logic slotFree;

  assign isoLive  = (epType == EP_TYPE_ISO) && (epStat == STAT_LIVE);
  assign slotFree = !frameUsed || sofPulse;

  always_comb begin
    strb.accept = tokenValid && isoLive && (tokenIsIn == epDir) && !inFlight && slotFree;
    strb.swap   = xferOk && inFlight && isoLive;
    strb.close  = (xferOk || xferFail) && inFlight;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epType    <= '0;
      epStat    <= STAT_OFF;
      epDir     <= 1'b0;
      inFlight  <= 1'b0;
      frameUsed <= 1'b0;
      respond   <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        epType <= cfgTypeIn;
        epStat <= cfgStatIn;
        epDir  <= cfgDirIn;
      end
      inFlight  <= strb.accept || (inFlight && !strb.close);
      frameUsed <= sofPulse ? strb.accept : (frameUsed || strb.accept);
      respond   <= strb.accept;
    end
  end

  AST_FAIL_NO_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (xferFail && !xferOk) |-> !strb.swap); // R7

  AST_RESPOND_HAS_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    respond |-> $past(tokenValid)); // R5
endmodule

// File: rtl/iso_ep_datapath.sv
module iso_ep_datapath
  import iso_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  isoStrobes_t       strb,
  input  logic [TYPE_W-1:0] epType,
  input  logic [STAT_W-1:0] epStat,
  input  logic              epDir,
  output logic              hwBufSel,
  output logic              appBufSel,
  output logic              pidData1,
  output logic              hsEnable,
  output logic              illegalCfg
);
  logic rxToggle;
  logic txToggle;
  logic isoMode;

  assign isoMode = (epType == EP_TYPE_ISO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxToggle <= 1'b0;
      txToggle <= 1'b0;
    end else if (strb.swap) begin
      if (epDir) txToggle <= !txToggle;
      else       rxToggle <= !rxToggle;
    end
  end

  always_comb begin
    hwBufSel   = epDir ? txToggle : rxToggle;
    appBufSel  = !hwBufSel;
    pidData1   = isoMode ? 1'b0 : hwBufSel;
    hsEnable   = !isoMode;
    illegalCfg = isoMode && (epStat != STAT_OFF) && (epStat != STAT_LIVE);
  end

  AST_ISO_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    isoMode |-> (!hsEnable && !pidData1)); // R1

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (epStat == STAT_OFF) |=> ($stable(rxToggle) && $stable(txToggle))); // R8

  AST_SWAP_FLIPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.swap |=> ((rxToggle ^ txToggle) != $past(rxToggle ^ txToggle))); // R6
endmodule

// File: rtl/iso_ep_buf_mgr.sv
module iso_ep_buf_mgr
  import iso_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgTypeIn,
  input  logic [1:0] cfgStatIn,
  input  logic       cfgDirIn,
  input  logic       sofPulse,
  input  logic       tokenValid,
  input  logic       tokenIsIn,
  input  logic       xferOk,
  input  logic       xferFail,
  output logic       respond,
  output logic       hwBufSel,
  output logic       appBufSel,
  output logic       pidData1,
  output logic       hsEnable,
  output logic       illegalCfg
);
  isoStrobes_t       strb;
  logic [TYPE_W-1:0] epType;
  logic [STAT_W-1:0] epStat;
  logic              epDir;

  iso_ep_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgTypeIn  (cfgTypeIn),
    .cfgStatIn  (cfgStatIn),
    .cfgDirIn   (cfgDirIn),
    .sofPulse   (sofPulse),
    .tokenValid (tokenValid),
    .tokenIsIn  (tokenIsIn),
    .xferOk     (xferOk),
    .xferFail   (xferFail),
    .epType     (epType),
    .epStat     (epStat),
    .epDir      (epDir),
    .strb       (strb),
    .respond    (respond)
  );

  iso_ep_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .epType     (epType),
    .epStat     (epStat),
    .epDir      (epDir),
    .hwBufSel   (hwBufSel),
    .appBufSel  (appBufSel),
    .pidData1   (pidData1),
    .hsEnable   (hsEnable),
    .illegalCfg (illegalCfg)
  );
endmodule

// File: tb/iso_ep_buf_mgr_tb.sv
`timescale 1ns/100ps
module iso_ep_buf_mgr_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn, cfgDirIn, sofPulse, tokenValid, tokenIsIn, xferOk, xferFail;
  logic [1:0] cfgTypeIn, cfgStatIn;
  logic respond, hwBufSel, appBufSel, pidData1, hsEnable, illegalCfg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the endpoint, derived from the requirements
  logic [1:0] mType, mStat;
  logic mDir, mRx, mTx, mUsed, mFly, mResp;

  always #2.5 clk = ~clk;

  iso_ep_buf_mgr dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTypeIn(cfgTypeIn),
    .cfgStatIn(cfgStatIn), .cfgDirIn(cfgDirIn), .sofPulse(sofPulse),
    .tokenValid(tokenValid), .tokenIsIn(tokenIsIn), .xferOk(xferOk),
    .xferFail(xferFail), .respond(respond), .hwBufSel(hwBufSel),
    .appBufSel(appBufSel), .pidData1(pidData1), .hsEnable(hsEnable),
    .illegalCfg(illegalCfg)
  );

  function automatic logic expIso();
    return mType == 2'b10;
  endfunction
  function automatic logic expHw();
    return mDir ? mTx : mRx;
  endfunction
  function automatic logic expIllegal();
    return expIso() && (mStat == 2'b01 || mStat == 2'b10);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check("R1 hsEnable", hsEnable, !expIso());
    check("R2 pidData1", pidData1, expIso() ? 1'b0 : expHw());
    check("R3 illegalCfg", illegalCfg, expIllegal());
    check("R4 hwBufSel", hwBufSel, expHw());
    check("R4 appBufSel", appBufSel, !expHw());
    check("R5/R9 respond", respond, mResp);
  endtask

  // one cycle: inputs driven at negedge, outputs compared 1 ns after posedge
  task automatic step(input logic wr, input logic [1:0] ty, input logic [1:0] st,
                      input logic dr, input logic sof, input logic tok,
                      input logic tin, input logic ok, input logic fl);
    logic acc, swp, live;
    cfgWrEn = wr; cfgTypeIn = ty; cfgStatIn = st; cfgDirIn = dr;
    sofPulse = sof; tokenValid = tok; tokenIsIn = tin; xferOk = ok; xferFail = fl;
    live = (mType == 2'b10) && (mStat == 2'b11);             // R11: old config
    acc  = tok && live && (tin == mDir) && !mFly && (!mUsed || sof);
    swp  = ok && mFly && live;
    @(posedge clk);
    if (swp) begin
      if (mDir) mTx = !mTx; else mRx = !mRx;
    end
    mFly  = acc || (mFly && !(ok || fl));
    mUsed = sof ? acc : (mUsed || acc);
    mResp = acc;
    if (wr) begin mType = ty; mStat = st; mDir = dr; end
    #1;
    checkAll();
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rstN = 1'b0;
    cfgWrEn = 0; cfgTypeIn = 0; cfgStatIn = 0; cfgDirIn = 0;
    sofPulse = 0; tokenValid = 0; tokenIsIn = 0; xferOk = 0; xferFail = 0;
    mType = 0; mStat = 0; mDir = 0; mRx = 0; mTx = 0; mUsed = 0; mFly = 0; mResp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check("R10 respond", respond, 1'b0);
    check("R10 hwBufSel", hwBufSel, 1'b0);
    check("R10 hsEnable", hsEnable, 1'b1);
    check("R10 illegalCfg", illegalCfg, 1'b0);

    // R8: disabled iso OUT endpoint ignores tokens, success never swaps
    step(1, 2'b10, 2'b00, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R8 no respond when disabled", respond, 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R8 no swap when disabled", hwBufSel, 1'b0);
    // R11: write valid and present a token in the same cycle -> old (disabled) config
    step(1, 2'b10, 2'b11, 0, 0, 1, 0, 0, 0);
    check("R11 token judged on old config", respond, 1'b0);
    // R5 accept, R6 swap of receive toggle
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R5 respond after token", respond, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R6 rx toggle flipped", hwBufSel, 1'b1);
    check("R4 app index inverse", appBufSel, 1'b0);
    // R9: second token in same frame ignored
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R9 second token ignored", respond, 1'b0);
    // R9: token together with SOF counts for new frame
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R9 token with sof accepted", respond, 1'b1);
    // R7: failure, no swap, no retry
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R7 no swap on fail", hwBufSel, 1'b1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    check("R7 no retry in same frame", respond, 1'b0);
    // R3 illegal statuses, R1/R2 non-iso type
    step(1, 2'b10, 2'b01, 1, 0, 0, 0, 0, 0);
    check("R3 status 01 illegal", illegalCfg, 1'b1);
    step(1, 2'b10, 2'b10, 1, 0, 0, 0, 0, 0);
    check("R3 status 10 illegal", illegalCfg, 1'b1);
    step(1, 2'b01, 2'b10, 1, 0, 0, 0, 0, 0);
    check("R3 non-iso not flagged", illegalCfg, 1'b0);
    check("R1 non-iso handshake on", hsEnable, 1'b1);
    // R4/R6: IN direction uses transmit toggle
    step(1, 2'b10, 2'b11, 1, 1, 0, 0, 0, 0);
    check("R4 IN uses tx toggle", hwBufSel, 1'b0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R6 tx toggle flipped", hwBufSel, 1'b1);
    check("R2 DATA0 in iso", pidData1, 1'b0);
    idle();

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic wr, dr, sof, tok, tin, ok, fl;
      logic [1:0] ty, st;
      wr  = ($urandom % 16) == 0;
      ty  = (($urandom % 4) != 0) ? 2'b10 : 2'($urandom);
      st  = (($urandom % 3) != 0) ? 2'b11 : 2'($urandom);
      dr  = 1'($urandom);
      sof = ($urandom % 8) == 0;
      tok = ($urandom % 3) == 0;
      tin = (($urandom % 4) != 0) ? mDir : 1'($urandom);
      ok  = ($urandom % 4) == 0;
      fl  = ($urandom % 5) == 0;
      step(wr, ty, st, dr, sof, tok, tin, ok, fl);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule